// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block joins two 18-bit buses, A and B, through two independent storage paths. One path carries A data to the B side and the other carries B data to the A side. Each path holds one storage bit per data bit. Depending on that path's latch enable and capture clock, the storage is transparent, holds its value, or loads the port on a rising capture-clock edge. Each path drives the opposite port through a three-state enable. The A-to-B enable is active high and the B-to-A enable is active low.

The block runs on a free-running system clock with a synchronous active-high reset. Each capture clock is sampled on that system clock, and a rise is seen as a low sample followed by a high sample. While a latch enable is high, the driven port follows the source port with no clock delay. When a port's enable is inactive, the block releases that port and another agent may drive it.

Top module: `xcv_bidir_latch_xcvr`

## Requirements
- R1: After a system clock edge with `rst` high, both stored values are all zeros. Either path shows this while its latch enable is low and its output is enabled.
- R2: While `ab_le` is 1 and `ab_oe` is 1, `b_io` equals `a_io` in the same cycle, with no clock delay.
- R3: While `ab_le` is 0, the A-to-B stored value does not change unless `ab_clk` rises. This holds while `ab_clk` stays high, while it stays low, and when it falls.
- R4: When `ab_le` is 0 and `ab_clk` is sampled high one system clock after being sampled low, the A-to-B storage loads `a_io` as it stands at that edge. `b_io` shows the new value from the next cycle.
- R5: `ab_oe` is active high. At 1 the block drives `b_io` with the A-to-B value. At 0 it releases `b_io`, so a value driven onto `b_io` from outside is seen unaltered.
- R6: The B-to-A path copies R2 to R4, using `ba_le` and `ba_clk`, storing `b_io` and driving `a_io`.
- R7: `ba_oe_n` is active low. At 0 the block drives `a_io` with the B-to-A value. At 1 it releases `a_io`, so an outside value on `a_io` is seen unaltered.
- R8: A capture-clock rise while the latch enable is 1 has no extra effect. After the latch enable falls, the stored value is the source port value at the last system clock edge with the enable still high.
- R9: A capture clock that is already high on the first edge after reset is not taken as a rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_io | inout | 18 | A-side bus: source for A-to-B, driven by B-to-A |
| b_io | inout | 18 | B-side bus: source for B-to-A, driven by A-to-B |
| ab_oe | input | 1 | Drive enable for `b_io`, active high |
| ab_le | input | 1 | A-to-B transparency enable |
| ab_clk | input | 1 | A-to-B capture clock, rising edge loads |
| ba_oe_n | input | 1 | Drive enable for `a_io`, active low |
| ba_le | input | 1 | B-to-A transparency enable |
| ba_clk | input | 1 | B-to-A capture clock, rising edge loads |

## Verification
The assertions assume that each bus carries a fully defined value in every cycle. They also assume that the two paths never form a combinational loop, which would happen if both ports were driven by the block while a latch enable is high. The stimulus therefore drives a port whenever the block has released it. It never enables both outputs together, so at least one bus always has an outside driver. Capture clocks change only between system clock edges, and each is held low across reset except in the R9 case.

// File: rtl/xcv_pkg.sv
package xcv_pkg;
  localparam int XCV_WIDTH_DEFAULT = 18;

  typedef enum logic [1:0] {
    XCV_PASS = 2'd0,
    XCV_HOLD = 2'd1,
    XCV_LOAD = 2'd2
  } xcv_mode_e;
endpackage

// File: rtl/xcv_rise_det.sv
module xcv_rise_det #(
  parameter bit IDLE_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  // prev_q starts high after reset, so a level that is already high is not a rise
  always_ff @(posedge clk) begin
    if (rst) prev_q <= IDLE_HIGH;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/xcv_store_path.sv
module xcv_store_path
  import xcv_pkg::*;
#(
  parameter int W = XCV_WIDTH_DEFAULT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  input  logic         le,
  input  logic         cap_clk,
  output logic [W-1:0] q,
  output logic [W-1:0] held
);
  logic      cap_rise;
  xcv_mode_e mode;

  xcv_rise_det #(.IDLE_HIGH(1'b1)) rise_i (
    .clk  (clk),
    .rst  (rst),
    .lvl  (cap_clk),
    .rise (cap_rise)
  );

  always_comb begin
    if (le)            mode = XCV_PASS;
    else if (cap_rise) mode = XCV_LOAD;
    else               mode = XCV_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
    end else begin
      unique case (mode)
        XCV_PASS, XCV_LOAD: held <= d;
        default:            held <= held;
      endcase
    end
  end

  // transparency bypasses the storage register
  assign q = le ? d : held;
endmodule

// File: rtl/xcv_oe_map.sv
module xcv_oe_map #(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic oe_pin,
  output logic drive
);
  generate
    if (ACTIVE_LOW) begin : g_low
      assign drive = ~oe_pin;
    end else begin : g_high
      assign drive = oe_pin;
    end
  endgenerate
endmodule

// File: rtl/xcv_bidir_latch_xcvr.sv
module xcv_bidir_latch_xcvr
  import xcv_pkg::*;
#(
  parameter int W = XCV_WIDTH_DEFAULT
) (
  input  logic         clk,
  input  logic         rst,
  inout  wire  [W-1:0] a_io,
  inout  wire  [W-1:0] b_io,
  input  logic         ab_oe,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_clk
);
  logic [W-1:0] ab_q, ab_held;
  logic [W-1:0] ba_q, ba_held;
  logic         ab_drive, ba_drive;

  xcv_store_path #(.W(W)) ab_path_i (
    .clk     (clk),
    .rst     (rst),
    .d       (a_io),
    .le      (ab_le),
    .cap_clk (ab_clk),
    .q       (ab_q),
    .held    (ab_held)
  );

  xcv_store_path #(.W(W)) ba_path_i (
    .clk     (clk),
    .rst     (rst),
    .d       (b_io),
    .le      (ba_le),
    .cap_clk (ba_clk),
    .q       (ba_q),
    .held    (ba_held)
  );

  xcv_oe_map #(.ACTIVE_LOW(1'b0)) ab_oe_i (.oe_pin(ab_oe),   .drive(ab_drive));
  xcv_oe_map #(.ACTIVE_LOW(1'b1)) ba_oe_i (.oe_pin(ba_oe_n), .drive(ba_drive));

  assign b_io = ab_drive ? ab_q : {W{1'bz}};
  assign a_io = ba_drive ? ba_q : {W{1'bz}};
endmodule

// File: rtl/xcv_chk.sv
module xcv_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_io,
  input logic [W-1:0] b_io,
  input logic         ab_oe,
  input logic         ab_le,
  input logic         ab_clk,
  input logic         ba_oe_n,
  input logic         ba_le,
  input logic         ba_clk,
  input logic [W-1:0] ab_held,
  input logic [W-1:0] ba_held
);
  logic rst_seen_q = 1'b0;

  always_ff @(posedge clk) rst_seen_q <= rst;

  // R1
  always_ff @(posedge clk) begin
    if (rst_seen_q) begin
      reset_zero_chk: assert (ab_held == '0 && ba_held == '0)
        else $error("storage not cleared by reset");
    end
  end

  // R2
  ab_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (ab_oe && ab_le) |-> (b_io == a_io));

  // R6
  ba_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!ba_oe_n && ba_le) |-> (a_io == b_io));

  // R8
  ab_track_chk: assert property (@(posedge clk) disable iff (rst)
    ab_le |=> (ab_held == $past(a_io)));

  // R8
  ba_track_chk: assert property (@(posedge clk) disable iff (rst)
    ba_le |=> (ba_held == $past(b_io)));

  // R3
  ab_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && !$rose(ab_clk)) |=> $stable(ab_held));

  // R6
  ba_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && !$rose(ba_clk)) |=> $stable(ba_held));

  // R4
  ab_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && $rose(ab_clk) && !$past(rst)) |=> (ab_held == $past(a_io)));

  // R6
  ba_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && $rose(ba_clk) && !$past(rst)) |=> (ba_held == $past(b_io)));

  // R5
  ab_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (ab_oe && !ab_le) |-> (b_io == ab_held));

  // R7
  ba_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (!ba_oe_n && !ba_le) |-> (a_io == ba_held));
endmodule

bind xcv_bidir_latch_xcvr xcv_chk #(.W(W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .a_io    (a_io),
  .b_io    (b_io),
  .ab_oe   (ab_oe),
  .ab_le   (ab_le),
  .ab_clk  (ab_clk),
  .ba_oe_n (ba_oe_n),
  .ba_le   (ba_le),
  .ba_clk  (ba_clk),
  .ab_held (ab_held),
  .ba_held (ba_held)
);

// File: tb/xcv_bidir_latch_xcvr_tb.sv
`timescale 1ns/1ps
module xcv_bidir_latch_xcvr_tb_top;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ab_oe = 1'b0, ab_le = 1'b0, ab_clk = 1'b0;
  logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_clk = 1'b0;
  logic [W-1:0] tb_a = '0, tb_b = '0;
  wire  [W-1:0] a_w, b_w;

  int nchk = 0;
  int nerr = 0;

  // reference state
  logic [W-1:0] m_hab = '0, m_hba = '0;
  logic         m_pab = 1'b1, m_pba = 1'b1;
  logic [W-1:0] a_seen, b_seen, ab_out, ba_out;

  always #2.5 clk = ~clk;

  assign a_w = ba_oe_n ? tb_a : {W{1'bz}};
  assign b_w = ab_oe   ? {W{1'bz}} : tb_b;

  xcv_bidir_latch_xcvr #(.W(W)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .a_io    (a_w),
    .b_io    (b_w),
    .ab_oe   (ab_oe),
    .ab_le   (ab_le),
    .ab_clk  (ab_clk),
    .ba_oe_n (ba_oe_n),
    .ba_le   (ba_le),
    .ba_clk  (ba_clk)
  );

  task automatic model_eval();
    if (ba_oe_n) begin
      a_seen = tb_a;
      ab_out = ab_le ? a_seen : m_hab;
      b_seen = ab_oe ? ab_out : tb_b;
      ba_out = ba_le ? b_seen : m_hba;
    end else begin
      b_seen = tb_b;
      ba_out = ba_le ? b_seen : m_hba;
      a_seen = ba_out;
      ab_out = ab_le ? a_seen : m_hab;
    end
  endtask

  task automatic model_clock();
    if (rst) begin
      m_hab = '0; m_hba = '0; m_pab = 1'b1; m_pba = 1'b1;
    end else begin
      if (ab_le || (ab_clk && !m_pab)) m_hab = a_seen;
      if (ba_le || (ba_clk && !m_pba)) m_hba = b_seen;
      m_pab = ab_clk;
      m_pba = ba_clk;
    end
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // inputs are set just after a falling edge; this checks both buses, then crosses a rising edge
  task automatic cyc(input string req);
    model_eval();
    #1;
    if (!rst) begin
      chk({req, " A bus"}, a_w, a_seen);
      chk({req, " B bus"}, b_w, b_seen);
    end
    @(posedge clk);
    model_clock();
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    nerr++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1'b1; cyc("R1"); cyc("R1");
    rst = 1'b0;
    // R1: stored zeros seen on B, then on A
    ab_oe = 1'b1; tb_a = 18'h2AAAA; cyc("R1");
    ab_oe = 1'b0; ba_oe_n = 1'b0; tb_b = 18'h15555; cyc("R1");
    ba_oe_n = 1'b1;

    // R2 transparent A to B, several patterns
    ab_oe = 1'b1; ab_le = 1'b1;
    tb_a = 18'h00001; cyc("R2");
    tb_a = 18'h3FFFF; cyc("R2");
    tb_a = 18'h12345; cyc("R2");
    tb_a = 18'h20000; cyc("R2");
    // R8: the last value seen while transparent is kept
    ab_le = 1'b0; tb_a = 18'h0F0F0; cyc("R8");
    // R3 hold with clock low, A changing
    tb_a = 18'h33333; cyc("R3");
    tb_a = 18'h00F00; cyc("R3");
    // R4 capture on rise, visible from the next cycle
    ab_clk = 1'b1; tb_a = 18'h2BEEF; cyc("R4");
    tb_a = 18'h11111; cyc("R4");
    // R3 clock held high: no further capture
    tb_a = 18'h22222; cyc("R3");
    // R3 falling edge: no capture
    ab_clk = 1'b0; tb_a = 18'h30303; cyc("R3");
    cyc("R3");
    ab_clk = 1'b1; tb_a = 18'h0ABCD; cyc("R4");
    ab_clk = 1'b0; cyc("R4");
    // R8: rise while transparent has no extra effect
    ab_le = 1'b1; tb_a = 18'h01234; cyc("R8");
    ab_clk = 1'b1; tb_a = 18'h04321; cyc("R8");
    ab_le = 1'b0; tb_a = 18'h3C3C3; cyc("R8");
    ab_clk = 1'b0; cyc("R8");
    // R5 release B, outside value seen
    ab_oe = 1'b0; tb_b = 18'h1DEAD; cyc("R5");
    tb_b = 18'h2FACE; cyc("R5");

    // R6/R7 B to A path, A driven by block
    ba_oe_n = 1'b0; ba_le = 1'b1;
    tb_b = 18'h00ABC; cyc("R6");
    tb_b = 18'h3F00F; cyc("R6");
    ba_le = 1'b0; tb_b = 18'h11100; cyc("R6");
    tb_b = 18'h22200; cyc("R6");
    ba_clk = 1'b1; tb_b = 18'h2C0DE; cyc("R6");
    tb_b = 18'h05050; cyc("R6");
    ba_clk = 1'b0; cyc("R6");
    ba_le = 1'b1; tb_b = 18'h01010; cyc("R8");
    ba_clk = 1'b1; tb_b = 18'h02020; cyc("R8");
    ba_le = 1'b0; tb_b = 18'h07070; cyc("R8");
    ba_clk = 1'b0; cyc("R8");
    // R7 release A
    ba_oe_n = 1'b1; tb_a = 18'h1BEAD; cyc("R7");
    // R7 re-enable: stored value returns
    ab_oe = 1'b0; ba_oe_n = 1'b0; cyc("R7");
    ba_oe_n = 1'b1;

    // R9: clocks high across reset release, no capture
    ab_clk = 1'b1; ba_clk = 1'b1; rst = 1'b1; cyc("R9");
    rst = 1'b0; tb_a = 18'h3ABCD; ab_oe = 1'b1; cyc("R9");
    tb_a = 18'h01111; cyc("R9");
    ab_oe = 1'b0; ba_oe_n = 1'b0; tb_b = 18'h2EEEE; cyc("R9");
    cyc("R9");
    ba_oe_n = 1'b1; ab_clk = 1'b0; ba_clk = 1'b0; cyc("R9");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule